// File: doc/BRIEF.md
# Two-Phase Block Copy Engine

This block copies a contiguous run of 64-bit words from a source buffer to a destination buffer over a local bus that it shares with a processor. The processor presents a source byte address, a destination byte address and a byte count, then pulses `start`. The engine raises a bus request and waits for the grant. It then moves the data one word at a time. Each word is read into an internal holding register in one cycle and written out of that register in the next cycle.

Both address counters advance by one word after each write. When the last word has been written, the engine pulses `done` for one cycle and withdraws its bus request in that same cycle. There is a single channel, so a second start is not honoured while a copy is in flight. Addresses are assumed to be word aligned. A byte count that does not fill the final word still copies that whole word.

Top module: `dma_mover`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `done`, `bus_req`, `rd_en` and `wr_en` are all low.
- R2: A `start` taken while idle with a nonzero count raises `bus_req` in the next cycle. `bus_req` stays high until the `done` cycle, and no strobe is issued before `bus_gnt` is seen.
- R3: Word k of a copy is read with one `rd_en` cycle at `rd_addr` = source + 8k. A later `wr_en` cycle writes it at `wr_addr` = destination + 8k, carrying the `rd_data` captured in the read cycle. `rd_en` and `wr_en` are never high together.
- R4: The number of words is the byte count divided by 8, rounded up. With the grant held high, the first read comes 2 cycles after the start edge and `done` comes 2N+2 cycles after it. A 1460-byte copy therefore takes 183 reads and 183 writes.
- R5: `done` is high for exactly one cycle, in the cycle after the final write. `bus_req` is low in that cycle, and `busy` falls in the following cycle.
- R6: A `start` pulse while `busy` is high is ignored. The copy in flight keeps its addresses and word count.
- R7: Strobes are issued only while `bus_gnt` is high. A lost grant freezes the engine in its current phase, and it resumes in that phase when the grant returns.
- R8: A `start` with a byte count of zero pulses `done` in the next cycle and never raises `bus_req` or a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a copy with the presented configuration |
| cfg_src | input | ADDR_W | Source byte address (word aligned) |
| cfg_dst | input | ADDR_W | Destination byte address (word aligned) |
| cfg_len | input | LEN_W | Byte count |
| busy | output | 1 | A copy is in progress |
| done | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Request for the shared bus |
| bus_gnt | input | 1 | Bus granted to the engine |
| rd_en | output | 1 | Source read strobe |
| rd_addr | output | ADDR_W | Source read address |
| rd_data | input | DATA_W | Source read data, valid in the strobe cycle |
| wr_en | output | 1 | Destination write strobe |
| wr_addr | output | ADDR_W | Destination write address |
| wr_data | output | DATA_W | Destination write data from the holding register |

## Verification
Two events can coincide. A grant loss can arrive in the same cycle as a read or write phase, and a new start can arrive while the engine is moving words. The bench drops `bus_gnt` at random in both phases and checks every strobe's address and data against a computed word pattern, so a phase that slips or repeats shows up as a mismatch. It also pulses `start` with different configuration in the middle of a copy, then confirms that the addresses and the word count of the running copy are unchanged.

// File: rtl/dma_mover_pkg.sv
package dma_mover_pkg;
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_REQ  = 3'd1,
      ST_RD   = 3'd2,
      ST_WR   = 3'd3,
      ST_FIN  = 3'd4
   } mover_state_e;
endpackage

// File: rtl/dma_mover_ctrl.sv
module dma_mover_ctrl
   import dma_mover_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic len_zero,
   input  logic last_word,
   input  logic bus_gnt,
   output logic load,
   output logic adv,
   output logic rd_en,
   output logic wr_en,
   output logic bus_req,
   output logic busy,
   output logic done,
   output logic in_wr
);
   mover_state_e state_q, state_d;

   assign load    = start && (state_q == ST_IDLE);
   assign rd_en   = (state_q == ST_RD) && bus_gnt;
   assign wr_en   = (state_q == ST_WR) && bus_gnt;
   assign adv     = wr_en;
   assign bus_req = (state_q == ST_REQ) || (state_q == ST_RD) || (state_q == ST_WR);
   assign busy    = (state_q != ST_IDLE);
   assign done    = (state_q == ST_FIN);
   assign in_wr   = (state_q == ST_WR);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (load) state_d = len_zero ? ST_FIN : ST_REQ;
         ST_REQ:  if (bus_gnt) state_d = ST_RD;
         ST_RD:   if (bus_gnt) state_d = ST_WR;
         ST_WR:   if (bus_gnt) state_d = last_word ? ST_FIN : ST_RD;
         ST_FIN:  state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_en && wr_en));
   p_rd_then_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> in_wr);
   p_strobe_gnt_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en || wr_en) |-> bus_gnt);
   p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_done_noreq_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !bus_req);
   p_done_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> ($past(wr_en) || $past(load)));
   p_start_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (start && busy) |-> !load);
endmodule

// File: rtl/dma_mover_addr.sv
module dma_mover_addr #(
   parameter int ADDR_W = 16,
   parameter int LEN_W  = 16,
   parameter int BYTES  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              adv,
   input  logic [ADDR_W-1:0] cfg_src,
   input  logic [ADDR_W-1:0] cfg_dst,
   input  logic [LEN_W-1:0]  cfg_len,
   output logic [ADDR_W-1:0] cur_src,
   output logic [ADDR_W-1:0] cur_dst,
   output logic              last_word,
   output logic              len_zero
);
   localparam int OFS_W = $clog2(BYTES);
   localparam int CNT_W = LEN_W - OFS_W + 1;
   localparam int NPTR  = 2;

   logic [CNT_W-1:0]  words_in, left_q;
   logic [ADDR_W-1:0] base [NPTR];
   logic [ADDR_W-1:0] ptr_q [NPTR];

   assign words_in  = CNT_W'(cfg_len[LEN_W-1:OFS_W]) + CNT_W'(|cfg_len[OFS_W-1:0]);
   assign len_zero  = (words_in == '0);
   assign last_word = (left_q == CNT_W'(1));
   assign base[0]   = cfg_src;
   assign base[1]   = cfg_dst;
   assign cur_src   = ptr_q[0];
   assign cur_dst   = ptr_q[1];

   for (genvar g = 0; g < NPTR; g++) begin : g_ptr
      always_ff @(posedge clk) begin
         if (!rst_n)    ptr_q[g] <= '0;
         else if (load) ptr_q[g] <= base[g];
         else if (adv)  ptr_q[g] <= ptr_q[g] + ADDR_W'(BYTES);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    left_q <= '0;
      else if (load) left_q <= words_in;
      else if (adv)  left_q <= left_q - CNT_W'(1);
   end

   p_adv_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      adv |-> (left_q != '0));
   p_hold_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !adv) |=> ($stable(cur_src) && $stable(cur_dst)));
endmodule

// File: rtl/dma_mover_hold.sv
module dma_mover_hold #(
   parameter int DATA_W   = 64,
   parameter bit HOLD_RST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap,
   input  logic [DATA_W-1:0] d,
   output logic [DATA_W-1:0] q
);
   logic [DATA_W-1:0] q_r;
   assign q = q_r;

   if (HOLD_RST) begin : g_rst
      always_ff @(posedge clk) begin
         if (!rst_n)   q_r <= '0;
         else if (cap) q_r <= d;
      end
   end else begin : g_norst
      always_ff @(posedge clk) begin
         if (cap) q_r <= d;
      end
   end

   p_hold_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !cap |=> $stable(q));
endmodule

// File: rtl/dma_mover.sv
module dma_mover #(
   parameter int DATA_W   = 64,
   parameter int ADDR_W   = 16,
   parameter int LEN_W    = 16,
   parameter bit HOLD_RST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] cfg_src,
   input  logic [ADDR_W-1:0] cfg_dst,
   input  logic [LEN_W-1:0]  cfg_len,
   output logic              busy,
   output logic              done,
   output logic              bus_req,
   input  logic              bus_gnt,
   output logic              rd_en,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [DATA_W-1:0] rd_data,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data
);
   localparam int BYTES = DATA_W / 8;

   if ((DATA_W % 8) != 0 || (BYTES & (BYTES - 1)) != 0 || BYTES < 2) begin : g_bad_w
      $error("dma_mover: DATA_W must be a power-of-two count of bytes");
   end
   if (LEN_W <= $clog2(BYTES) || ADDR_W <= $clog2(BYTES)) begin : g_bad_len
      $error("dma_mover: LEN_W and ADDR_W must exceed the word offset width");
   end

   logic load, adv, last_word, len_zero, in_wr;

   dma_mover_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .len_zero(len_zero),
      .last_word(last_word), .bus_gnt(bus_gnt), .load(load), .adv(adv),
      .rd_en(rd_en), .wr_en(wr_en), .bus_req(bus_req), .busy(busy),
      .done(done), .in_wr(in_wr)
   );

   dma_mover_addr #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BYTES(BYTES)) u_addr (
      .clk(clk), .rst_n(rst_n), .load(load), .adv(adv),
      .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_len(cfg_len),
      .cur_src(rd_addr), .cur_dst(wr_addr),
      .last_word(last_word), .len_zero(len_zero)
   );

   dma_mover_hold #(.DATA_W(DATA_W), .HOLD_RST(HOLD_RST)) u_hold (
      .clk(clk), .rst_n(rst_n), .cap(rd_en), .d(rd_data), .q(wr_data)
   );

   p_wr_needs_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> in_wr);
   p_req_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !len_zero) |=> bus_req);
   p_zero_noreq_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (load && len_zero) |=> (done && !bus_req));
endmodule

// File: tb/dma_mover_tb_top.sv
module dma_mover_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] cfg_src = '0, cfg_dst = '0, cfg_len = '0;
   logic        busy, done, bus_req, rd_en, wr_en;
   logic        bus_gnt = 1'b0;
   logic [15:0] rd_addr, wr_addr;
   logic [63:0] rd_data, wr_data;
   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   function automatic logic [63:0] patt(input logic [15:0] a);
      return {a, ~a, a ^ 16'hA5C3, a + 16'h1357};
   endfunction

   assign rd_data = patt(rd_addr);

   dma_mover dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .cfg_src(cfg_src),
      .cfg_dst(cfg_dst), .cfg_len(cfg_len), .busy(busy), .done(done),
      .bus_req(bus_req), .bus_gnt(bus_gnt), .rd_en(rd_en), .rd_addr(rd_addr),
      .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // One copy; sampled at negedge, inputs changed right after sampling
   task automatic xfer(input logic [15:0] s, input logic [15:0] d,
                       input logic [15:0] len, input int gnt_pct, input bit poke);
      int nw = (int'(len) + 7) / 8;
      int rds = 0, wrs = 0, cyc = 0, first_rd = -1, done_cyc = -1;
      bit seen_req = 0;
      @(negedge clk);
      cfg_src = s; cfg_dst = d; cfg_len = len; start = 1'b1;
      bus_gnt = (gnt_pct >= 100) ? 1'b1 : ($urandom_range(99) < gnt_pct);
      @(negedge clk);
      start = 1'b0; cyc = 1;
      while (done_cyc < 0 && cyc < 4000) begin
         if (cyc == 1 && len != 0)
            chk(bus_req, "R2", "bus_req after start", bus_req, 1);
         if (bus_req) seen_req = 1;
         chk(!(rd_en && wr_en), "R3", "strobe overlap", {rd_en, wr_en}, 0);
         if ((rd_en || wr_en) && !bus_gnt)
            chk(0, "R7", "strobe without grant", 1, 0);
         if (rd_en) begin
            chk(rd_addr == s + 16'(8 * rds), "R3", "rd_addr", rd_addr, s + 16'(8 * rds));
            if (first_rd < 0) first_rd = cyc;
            rds++;
         end
         if (wr_en) begin
            chk(wr_addr == d + 16'(8 * wrs), "R3", "wr_addr", wr_addr, d + 16'(8 * wrs));
            chk(wr_data == patt(s + 16'(8 * wrs)), "R3", "wr_data",
                wr_data, patt(s + 16'(8 * wrs)));
            wrs++;
         end
         if (done) begin
            done_cyc = cyc;
            chk(!bus_req, "R5", "bus_req in done cycle", bus_req, 0);
            chk(rds == nw && wrs == nw, "R4", "word count", rds * 10000 + wrs, nw * 10001);
         end else if (len != 0 && !bus_req)
            chk(0, "R2", "bus_req dropped early", 0, 1);
         if (poke && cyc == 3) begin
            start = 1'b1; cfg_src = s ^ 16'h0F08; cfg_dst = d ^ 16'h3018; cfg_len = len + 16'd64;
         end else start = 1'b0;
         if (gnt_pct < 100) bus_gnt = ($urandom_range(99) < gnt_pct);
         @(negedge clk); cyc++;
      end
      start = 1'b0;
      chk(done_cyc >= 0, "R5", "done seen", done_cyc, 1);
      chk(!done && !busy, "R5", "done single cycle, busy clear", {done, busy}, 0);
      if (len == 0)
         chk(done_cyc == 1 && !seen_req && rds == 0, "R8", "zero length",
             done_cyc * 10 + rds, 10);
      else if (gnt_pct >= 100) begin
         chk(first_rd == 2, "R4", "first read cycle", first_rd, 2);
         chk(done_cyc == 2 * nw + 2, "R4", "done cycle", done_cyc, 2 * nw + 2);
      end
      bus_gnt = 1'b0;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      chk(!busy && !done && !bus_req && !rd_en && !wr_en, "R1", "in reset",
          {busy, done, bus_req, rd_en, wr_en}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !bus_req && !rd_en && !wr_en, "R1", "after reset",
          {busy, done, bus_req, rd_en, wr_en}, 0);
      // R2/R7: request held without grant, no strobes
      cfg_src = 16'h0100; cfg_dst = 16'h0800; cfg_len = 16'd16; start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (4) begin
         chk(bus_req && !rd_en && !wr_en, "R2", "waiting for grant",
             {bus_req, rd_en, wr_en}, 4);
         @(negedge clk);
      end
      bus_gnt = 1'b1;
      while (!done) @(negedge clk);
      @(negedge clk); bus_gnt = 1'b0;
      xfer(16'h0200, 16'h4000, 16'd1460, 100, 0);   // R4 183 words
      xfer(16'h1000, 16'h2000, 16'd1, 100, 0);      // R4 round up
      xfer(16'h1008, 16'h2008, 16'd8, 100, 0);
      xfer(16'h1010, 16'h2010, 16'd9, 100, 0);
      xfer(16'h3000, 16'h5000, 16'd0, 100, 0);      // R8
      xfer(16'h0040, 16'h0840, 16'd200, 100, 1);    // R6 start while busy
      xfer(16'h0080, 16'h0880, 16'd120, 60, 1);     // R6 with R7
      xfer(16'hFFF0, 16'h0010, 16'd40, 50, 0);      // address wrap, R7
      for (int i = 0; i < 20; i++) begin
         logic [15:0] s = {16'($urandom) & 16'hFFF8};
         logic [15:0] d = {16'($urandom) & 16'hFFF8};
         logic [15:0] l = 16'($urandom_range(0, 600));
         xfer(s, d, l, (i % 3 == 0) ? 100 : 30 + int'($urandom_range(60)), i[0]);
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule